// File: doc/BRIEF.md
# Compressed instruction expander

This unit sits between instruction fetch and decode in a core that runs two instruction sets: a 32-bit normal set and a 16-bit compressed set. Fetch hands it aligned 32-bit words. In normal mode each word goes to the decoder unchanged. In compressed mode each word holds two 16-bit instructions, and the lower half is taken first. Each compressed instruction becomes exactly one 32-bit normal instruction, so the decoder only ever sees the normal set.

The unit keeps the current mode. It consumes the mode-switch, padding and immediate-prefix instructions itself, and none of them reaches the decoder. It widens register fields and fills in implied operands. A dedicated move form keeps all sixteen registers reachable while in compressed mode. Both edges use a valid/ready handshake. The output is registered, and the fetch side is stalled whenever the decoder is not ready.

Normal instruction layout: bits [31:24] hold the major opcode, [23:12] a 12-bit immediate, [11:8] the destination, [7:4] source 1 and [3:0] source 2. Compressed layout: [15:9] hold the opcode, [8:6] field x (destination), [5:3] field y (source 1) and [2:0] field z (source 2). A 3-bit field names register `{0,field}`.

Top module: `cx_expander`

## Requirements
- R1: In normal mode, a fetch word other than the enter word 32'hF000_0000 is emitted unchanged, one cycle after it is accepted.
- R2: In normal mode, the word 32'hF000_0000 emits nothing and selects compressed mode. In compressed mode the lower half of a word is expanded before the upper half.
- R3: The register forms ADD (opcode 7'h01), SUB (7'h02) and AND (7'h03) expand to major 8'h10, 8'h11 and 8'h12 respectively, with immediate 0 and registers {0,x}, {0,y}, {0,z}.
- R4: The immediate forms ADDI (7'h04) and LOAD (7'h05) expand to major 8'h20 and 8'h21 respectively, with destination {0,x}, source 1 {0,y}, source 2 = 0, and immediate = z zero-extended when no prefix is pending.
- R5: The extend prefix (7'h7E) emits nothing and stores its 9 low bits. The next emitted instruction of an immediate form uses {prefix bits, z} as its immediate. The stored bits are discarded once any instruction is emitted.
- R6: The padding no-op (7'h00) emits nothing and leaves a pending prefix in place.
- R7: The move form (7'h7D) expands to major 8'h30, with destination = bits [8:5], source 1 = bits [4:1], source 2 = 0 and immediate 0. Any of the 16 registers can be named.
- R8: The implied two-operand add (7'h06) expands to major 8'h10 with registers {0,x}, {0,y}, {0,y}. The implied single-operand add (7'h07) expands to major 8'h20 with immediate 4, registers {0,x}, {0,x}, 0.
- R9: The compressed switch (7'h7F) emits nothing and returns to normal mode. When it sits in the lower half, the upper half of that word is skipped. The next word is handled in normal mode.
- R10: fetch_ready is low whenever out_ready is low. While out_valid is high and out_ready is low, out_valid and out_insn hold.
- R11: After reset the unit is in normal mode with out_valid low.
- R12: Any other compressed opcode expands to 32'hFF00_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch word present |
| fetch_word | input | 32 | Aligned fetch word |
| fetch_ready | output | 1 | Word fully consumed this cycle |
| out_valid | output | 1 | Expanded instruction present |
| out_insn | output | 32 | Normal-set instruction for the decoder |
| out_ready | input | 1 | Decoder accepts the instruction |

## Verification
A wrong mode bit shows up at once: the next word is either emitted raw or split into two garbage instructions, so the next output comparison fails. A wrong half pointer reorders or duplicates instructions within one word, or consumes the word early, which appears as a fetch_ready pulse one handshake out of place. A prefix register that is not cleared corrupts the immediate of the next immediate-form instruction, and a lost prefix appears in the instruction that follows a padding no-op. All of these faults reach out_insn within two emitted instructions.

// File: rtl/cx_pkg.sv
package cx_pkg;
    parameter int unsigned XW   = 32;  // normal instruction width
    parameter int unsigned HW   = 16;  // compressed instruction width
    parameter int unsigned OPW  = 7;   // compressed opcode width
    parameter int unsigned FW   = 3;   // compressed register field width
    parameter int unsigned RW   = 4;   // normal register field width
    parameter int unsigned MAJW = 8;   // normal major opcode width
    parameter int unsigned IMMW = 12;  // normal immediate width

    localparam int unsigned EXTW = IMMW - FW;  // prefix bits stored
    localparam int unsigned AW   = HW - OPW;   // argument bits after opcode

    typedef enum logic [3:0] {
        F_REG3, F_IMM, F_ADD2, F_ADD4, F_MOVE, F_NOP, F_EXT, F_SWITCH, F_ILL
    } form_e;

    typedef enum logic [1:0] {K_EMIT, K_NOP, K_EXT, K_SWITCH} kind_e;

    typedef struct packed {
        logic            cmode;
        logic            hsel;
        logic            ext_vld;
        logic [EXTW-1:0] ext_bits;
        logic            ovld;
        logic [XW-1:0]   oinsn;
    } state_t;

    localparam logic [XW-1:0]   ENTER_WORD = 32'hF000_0000;
    localparam logic [OPW-1:0]  OP_NOP  = 7'h00;
    localparam logic [OPW-1:0]  OP_ADD  = 7'h01;
    localparam logic [OPW-1:0]  OP_SUB  = 7'h02;
    localparam logic [OPW-1:0]  OP_AND  = 7'h03;
    localparam logic [OPW-1:0]  OP_ADDI = 7'h04;
    localparam logic [OPW-1:0]  OP_LOAD = 7'h05;
    localparam logic [OPW-1:0]  OP_ADD2 = 7'h06;
    localparam logic [OPW-1:0]  OP_ADD4 = 7'h07;
    localparam logic [OPW-1:0]  OP_MOVE = 7'h7D;
    localparam logic [OPW-1:0]  OP_EXT  = 7'h7E;
    localparam logic [OPW-1:0]  OP_SWCH = 7'h7F;

    localparam logic [MAJW-1:0] MJ_ADD  = 8'h10;
    localparam logic [MAJW-1:0] MJ_SUB  = 8'h11;
    localparam logic [MAJW-1:0] MJ_AND  = 8'h12;
    localparam logic [MAJW-1:0] MJ_ADDI = 8'h20;
    localparam logic [MAJW-1:0] MJ_LOAD = 8'h21;
    localparam logic [MAJW-1:0] MJ_MOVE = 8'h30;
    localparam logic [MAJW-1:0] MJ_ILL  = 8'hFF;
    localparam logic [IMMW-1:0] IMP_IMM = 12'd4;
endpackage

// File: rtl/cx_lut.sv
module cx_lut
    import cx_pkg::*;
(
    input  logic [OPW-1:0]  op,
    output form_e           form,
    output logic [MAJW-1:0] maj
);
    always_comb begin
        form = F_ILL;
        maj  = MJ_ILL;
        case (op)
            OP_NOP:  begin form = F_NOP;    maj = '0;      end
            OP_ADD:  begin form = F_REG3;   maj = MJ_ADD;  end
            OP_SUB:  begin form = F_REG3;   maj = MJ_SUB;  end
            OP_AND:  begin form = F_REG3;   maj = MJ_AND;  end
            OP_ADDI: begin form = F_IMM;    maj = MJ_ADDI; end
            OP_LOAD: begin form = F_IMM;    maj = MJ_LOAD; end
            OP_ADD2: begin form = F_ADD2;   maj = MJ_ADD;  end
            OP_ADD4: begin form = F_ADD4;   maj = MJ_ADDI; end
            OP_MOVE: begin form = F_MOVE;   maj = MJ_MOVE; end
            OP_EXT:  begin form = F_EXT;    maj = '0;      end
            OP_SWCH: begin form = F_SWITCH; maj = '0;      end
            default: begin form = F_ILL;    maj = MJ_ILL;  end
        endcase
    end
endmodule

// File: rtl/cx_halfexp.sv
module cx_halfexp
    import cx_pkg::*;
(
    input  logic [HW-1:0]   unit,
    input  logic            ext_vld,
    input  logic [EXTW-1:0] ext_bits,
    output kind_e           kind,
    output logic [XW-1:0]   insn
);
    localparam int unsigned PADW = RW - FW;

    form_e           form;
    logic [MAJW-1:0] maj;
    logic [RW-1:0]   rx, ry, rz, mv_d, mv_s;
    logic [IMMW-1:0] imm_z;

    cx_lut u_lut (.op(unit[HW-1 -: OPW]), .form(form), .maj(maj));

    // widen the three short fields; the move form reads two full fields
    assign rx    = {{PADW{1'b0}}, unit[3*FW-1 -: FW]};
    assign ry    = {{PADW{1'b0}}, unit[2*FW-1 -: FW]};
    assign rz    = {{PADW{1'b0}}, unit[FW-1:0]};
    assign mv_d  = unit[AW-1 -: RW];
    assign mv_s  = unit[AW-1-RW -: RW];
    assign imm_z = ext_vld ? {ext_bits, unit[FW-1:0]}
                           : {{EXTW{1'b0}}, unit[FW-1:0]};

    always_comb begin
        kind = K_EMIT;
        insn = {MJ_ILL, {(XW-MAJW){1'b0}}};
        case (form)
            F_REG3:   insn = {maj, {IMMW{1'b0}}, rx, ry, rz};
            F_IMM:    insn = {maj, imm_z, rx, ry, {RW{1'b0}}};
            F_ADD2:   insn = {maj, {IMMW{1'b0}}, rx, ry, ry};
            F_ADD4:   insn = {maj, IMP_IMM, rx, rx, {RW{1'b0}}};
            F_MOVE:   insn = {maj, {IMMW{1'b0}}, mv_d, mv_s, {RW{1'b0}}};
            F_NOP:    kind = K_NOP;
            F_EXT:    kind = K_EXT;
            F_SWITCH: kind = K_SWITCH;
            default:  insn = {maj, {(XW-MAJW){1'b0}}};
        endcase
    end
endmodule

// File: rtl/cx_expander.sv
module cx_expander
    import cx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [XW-1:0] fetch_word,
    output logic          fetch_ready,
    output logic          out_valid,
    output logic [XW-1:0] out_insn,
    input  logic          out_ready
);
    state_t        st_d, st_q;
    logic [HW-1:0] cur_unit;
    kind_e         hk;
    logic [XW-1:0] hinsn;
    logic          cmode_w;

    assign cur_unit = st_q.hsel ? fetch_word[XW-1 -: HW] : fetch_word[HW-1:0];

    cx_halfexp u_half (
        .unit(cur_unit), .ext_vld(st_q.ext_vld), .ext_bits(st_q.ext_bits),
        .kind(hk), .insn(hinsn)
    );

    always_comb begin
        st_d        = st_q;
        fetch_ready = 1'b0;
        if (out_ready) begin
            st_d.ovld = 1'b0;
            if (fetch_valid) begin
                if (!st_q.cmode) begin
                    fetch_ready = 1'b1;
                    if (fetch_word == ENTER_WORD) begin
                        st_d.cmode = 1'b1;
                        st_d.hsel  = 1'b0;
                    end else begin
                        st_d.ovld  = 1'b1;
                        st_d.oinsn = fetch_word;
                    end
                end else if (hk == K_SWITCH) begin
                    // the rest of the word is dropped; normal starts aligned
                    fetch_ready    = 1'b1;
                    st_d.cmode     = 1'b0;
                    st_d.hsel      = 1'b0;
                    st_d.ext_vld   = 1'b0;
                end else begin
                    if (hk == K_EXT) begin
                        st_d.ext_vld  = 1'b1;
                        st_d.ext_bits = cur_unit[EXTW-1:0];
                    end else if (hk == K_EMIT) begin
                        st_d.ovld     = 1'b1;
                        st_d.oinsn    = hinsn;
                        st_d.ext_vld  = 1'b0;
                    end
                    fetch_ready = st_q.hsel;
                    st_d.hsel   = ~st_q.hsel;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ovld;
    assign out_insn  = st_q.oinsn;
    assign cmode_w   = st_q.cmode;
endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk
    import cx_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_valid,
    input logic [XW-1:0] fetch_word,
    input logic          fetch_ready,
    input logic          out_valid,
    input logic [XW-1:0] out_insn,
    input logic          out_ready,
    input logic          cmode
);
    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmode && fetch_valid && fetch_ready && fetch_word != ENTER_WORD)
        |=> (out_valid && out_insn == $past(fetch_word)));

    // R2
    enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmode && fetch_valid && fetch_ready && fetch_word == ENTER_WORD)
        |=> (cmode && !out_valid));

    // R10
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !fetch_ready);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_insn)));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !cmode));
endmodule

bind cx_expander cx_expander_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .fetch_word(fetch_word), .fetch_ready(fetch_ready),
    .out_valid(out_valid), .out_insn(out_insn), .out_ready(out_ready),
    .cmode(cmode_w)
);

// File: tb/cx_expander_tb.sv
`timescale 1ns/1ps
module cx_expander_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        fetch_ready;
    logic        out_valid;
    logic [31:0] out_insn;
    logic        out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] prog[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cx_expander u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_word(fetch_word), .fetch_ready(fetch_ready),
        .out_valid(out_valid), .out_insn(out_insn), .out_ready(out_ready)
    );

    function automatic logic [15:0] cw(logic [6:0] op, logic [2:0] x, logic [2:0] y, logic [2:0] z);
        return {op, x, y, z};
    endfunction

    function automatic logic [31:0] ni(logic [7:0] m, logic [11:0] imm, logic [3:0] d, logic [3:0] a, logic [3:0] b);
        return {m, imm, d, a, b};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_out(logic [31:0] v, string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic monitor();
        logic [7:0]  lfsr = 8'hA5;
        logic        prev_stall = 1'b0;
        logic [31:0] prev_insn = '0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = (lfsr[1:0] != 2'b00);
            #2;
            if (prev_stall) begin
                check("R10 hold valid", {31'b0, out_valid}, 32'd1);
                check("R10 hold insn", out_insn, prev_insn);
            end
            if (!out_ready) check("R10 ready gated", {31'b0, fetch_ready}, 32'd0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("unexpected output", out_insn, 32'hxxxxxxxx);
                end else begin
                    string t;
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, out_insn, e);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_insn  = out_insn;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        // program and the expected instruction stream
        prog.push_back(ni(8'h41, 12'h123, 4'd9, 4'd10, 4'd11));
        expect_out(ni(8'h41, 12'h123, 4'd9, 4'd10, 4'd11), "R1 passthrough");
        prog.push_back(32'h1234_5678);
        expect_out(32'h1234_5678, "R1 passthrough 2");
        prog.push_back(32'hF000_0000);                               // R2 enter
        prog.push_back({cw(7'h02, 3'd7, 3'd6, 3'd5), cw(7'h01, 3'd1, 3'd2, 3'd3)});
        expect_out(ni(8'h10, 12'h0, 4'd1, 4'd2, 4'd3), "R2/R3 lower half ADD");
        expect_out(ni(8'h11, 12'h0, 4'd7, 4'd6, 4'd5), "R3 upper half SUB");
        prog.push_back({7'h7E, 9'h1AB, cw(7'h04, 3'd2, 3'd3, 3'd5)});
        expect_out(ni(8'h20, 12'd5, 4'd2, 4'd3, 4'd0), "R4 ADDI no prefix");
        prog.push_back({cw(7'h05, 3'd4, 3'd1, 3'd6), cw(7'h00, 3'd0, 3'd0, 3'd0)});
        expect_out(ni(8'h21, {9'h1AB, 3'd6}, 4'd4, 4'd1, 4'd0), "R5/R6 prefix across nop");
        prog.push_back({7'h7D, 4'd13, 4'd9, 1'b0, cw(7'h04, 3'd1, 3'd1, 3'd2)});
        expect_out(ni(8'h20, 12'd2, 4'd1, 4'd1, 4'd0), "R5 prefix cleared");
        expect_out(ni(8'h30, 12'h0, 4'd13, 4'd9, 4'd0), "R7 move high regs");
        prog.push_back({cw(7'h07, 3'd6, 3'd2, 3'd1), cw(7'h06, 3'd5, 3'd3, 3'd7)});
        expect_out(ni(8'h10, 12'h0, 4'd5, 4'd3, 4'd3), "R8 implied two-operand");
        expect_out(ni(8'h20, 12'd4, 4'd6, 4'd6, 4'd0), "R8 implied add four");
        prog.push_back({cw(7'h03, 3'd0, 3'd0, 3'd1), 7'h7E, 9'h0FF});
        expect_out(ni(8'h12, 12'h0, 4'd0, 4'd0, 4'd1), "R3 AND after prefix");
        prog.push_back({cw(7'h40, 3'd3, 3'd3, 3'd3), cw(7'h04, 3'd3, 3'd3, 3'd1)});
        expect_out(ni(8'h20, 12'd1, 4'd3, 4'd3, 4'd0), "R5 prefix dropped by reg form");
        expect_out(32'hFF00_0000, "R12 unmapped opcode");
        prog.push_back({cw(7'h01, 3'd1, 3'd1, 3'd1), cw(7'h7F, 3'd0, 3'd0, 3'd0)});
        prog.push_back(32'hDEAD_BEEF);
        expect_out(32'hDEAD_BEEF, "R9 normal after lower-half switch");
        prog.push_back(32'hF000_0000);
        prog.push_back({cw(7'h7F, 3'd0, 3'd0, 3'd0), cw(7'h01, 3'd2, 3'd2, 3'd2)});
        expect_out(ni(8'h10, 12'h0, 4'd2, 4'd2, 4'd2), "R9 before upper-half switch");
        prog.push_back(32'h0BAD_F00D);
        expect_out(32'h0BAD_F00D, "R9 normal after upper-half switch");

        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        check("R11 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R11 reset fetch_ready", {31'b0, fetch_ready}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        fork monitor(); join_none

        for (int i = 0; i < prog.size(); i++) begin
            bit acc;
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                fetch_valid = 1'b1;
                fetch_word  = prog[i];
                #2;
                acc = fetch_ready;
            end
            if (i % 3 == 2) begin
                @(negedge clk);
                fetch_valid = 1'b0;
                fetch_word  = 32'hF000_0000;
            end
        end
        @(negedge clk);
        fetch_valid = 1'b0;

        for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        check("R1-stream all outputs seen", exp_q.size(), 32'd0);
        summary();
        $finish;
    end
endmodule